// File: doc/BRIEF.md
# PHY Post-Reset Calibration Sequencer

After the host controller comes out of reset, and again after each bus resume, some PHY analog settings have to be overridden before SuperSpeed links train correctly. This block does that work. A single start pulse makes it issue three override writes, one after another, through a simple write-engine port. It waits for each write to finish before it presents the next one. When the sequence ends it gives a one-cycle done pulse, and an error flag tells the caller whether any write timed out.

The last write sets the receiver-detect measurement time, and its value depends on the PHY reference clock. The block captures the frequency-select code when it accepts a start and keeps that captured value for the whole sequence. Some platforms need no overrides at all. For them, a build parameter turns the sequencer into a stub that acknowledges a start at once with a clean done, so the caller can read the result as "not supported" rather than as a failure.

Top module: `phy_cal_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, busy_o, done_o, err_o and wr_valid_o are all 0.
- R2: A start_i pulse accepted while idle makes busy_o 1 in the next cycle. In that same cycle the first write is presented: address 0x0015, data 0xA409. The data holds a loss-of-signal bias of 5 in bits [15:13], the override enable at bit 10 and a loss-of-signal level of 9 in bits [4:0].
- R3: The second write goes to address 0x0012 with data 0xA000, which is a transmit boost level of 5 in bits [15:13].
- R4: The third write goes to address 0x1010. Its data is a receiver-detect time placed from bit 4 upward, chosen from the fsel_i code captured at start: 0 (19.2 MHz) or 1 (20 MHz) gives 0x0040, 3 (50 MHz) gives 0x0200, and 2 (24 MHz) or any other code gives 0x0080.
- R5: Writes go out strictly in the order 0x0015, 0x0012, 0x1010, one at a time. A write is finished at a clock edge where wr_valid_o is 1 and wr_ready_i or wr_timeout_i is 1. Until then its address and data hold steady. The next write is presented in the cycle right after.
- R6: done_o is 1 for exactly one cycle, the cycle after the last write finishes. busy_o is 0 in the cycle after that.
- R7: A start_i pulse that arrives while busy_o is 1 is ignored. It does not change the captured frequency code and it does not add any writes or done pulses.
- R8: A timeout on any write sets err_o from the next cycle. The remaining writes are still issued. err_o is still 1 during done and stays 1 until the next accepted start clears it.
- R9: With ENABLE_CAL set to 0, an accepted start gives done_o in the next cycle with err_o at 0, and wr_valid_o never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a calibration run |
| fsel_i | input | 3 | Reference-clock frequency code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | A write timed out during the last run |
| wr_addr_o | output | 16 | PHY register address of the current write |
| wr_data_o | output | 16 | Data of the current write |
| wr_valid_o | output | 1 | Write request |
| wr_ready_i | input | 1 | Write finished successfully |
| wr_timeout_i | input | 1 | Write finished with a timeout |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a run, carrying a different frequency code. The bench stalls the write engine so that the sequencer is known to be busy, then pulses start with a 50 MHz code. The scoreboard still expects only three writes and a third write that matches the original code. A second hard case is a timeout on the middle write. The bench's responder returns timeout instead of ready for one chosen write index, then checks that the third write is still issued, that err_o is still 1 after done, and that err_o clears only when the next run starts.

// File: rtl/phy_cal_pkg.sv
package phy_cal_pkg;

  localparam int CAL_AW = 16;
  localparam int CAL_DW = 16;
  localparam int CAL_FSEL_W = 3;
  localparam int CAL_STEPS = 3;

  // reference-clock codes
  localparam logic [CAL_FSEL_W-1:0] FSEL_19M2 = 3'd0;
  localparam logic [CAL_FSEL_W-1:0] FSEL_20M  = 3'd1;
  localparam logic [CAL_FSEL_W-1:0] FSEL_24M  = 3'd2;
  localparam logic [CAL_FSEL_W-1:0] FSEL_50M  = 3'd3;

  // override targets, in issue order
  localparam logic [CAL_AW-1:0] ADDR_LOS   = 16'h0015;
  localparam logic [CAL_AW-1:0] ADDR_BOOST = 16'h0012;
  localparam logic [CAL_AW-1:0] ADDR_RXDET = 16'h1010;

  localparam int LOS_BIAS_LSB = 13;
  localparam int LOS_OVRD_BIT = 10;
  localparam int BOOST_LSB    = 13;
  localparam int RXDET_LSB    = 4;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_ISSUE = 2'd1,
    CS_DONE  = 2'd2
  } cal_state_e;

  typedef struct packed {
    logic [CAL_AW-1:0] addr;
    logic [CAL_DW-1:0] data;
  } cal_wr_t;

  function automatic logic [CAL_DW-1:0] los_word();
    logic [CAL_DW-1:0] w;
    w = '0;
    w[LOS_BIAS_LSB +: 3] = 3'd5;
    w[LOS_OVRD_BIT]      = 1'b1;
    w[4:0]               = 5'd9;
    return w;
  endfunction

  function automatic logic [CAL_DW-1:0] boost_word();
    logic [CAL_DW-1:0] w;
    w = '0;
    w[BOOST_LSB +: 3] = 3'd5;
    return w;
  endfunction

  function automatic logic [CAL_DW-1:0] rxdet_word(input logic [CAL_FSEL_W-1:0] f);
    logic [7:0] t;
    case (f)
      FSEL_19M2, FSEL_20M: t = 8'h04;
      FSEL_50M:            t = 8'h20;
      default:             t = 8'h08;  // 24 MHz and unlisted codes
    endcase
    return {{(CAL_DW-8){1'b0}}, t} << RXDET_LSB;
  endfunction

  function automatic cal_wr_t cal_entry(input int unsigned step,
                                        input logic [CAL_FSEL_W-1:0] f);
    cal_wr_t e;
    case (step)
      0:       begin e.addr = ADDR_LOS;   e.data = los_word();    end
      1:       begin e.addr = ADDR_BOOST; e.data = boost_word();  end
      default: begin e.addr = ADDR_RXDET; e.data = rxdet_word(f); end
    endcase
    return e;
  endfunction

endpackage

// File: rtl/cal_step_table.sv
module cal_step_table
  import phy_cal_pkg::*;
#(
  parameter int NUM_STEPS = CAL_STEPS,
  localparam int STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
  input  logic [STEP_W-1:0]     step_i,
  input  logic [CAL_FSEL_W-1:0] fsel_i,
  output logic [CAL_AW-1:0]     addr_o,
  output logic [CAL_DW-1:0]     data_o
);

  cal_wr_t entry;

  always_comb begin
    entry  = cal_entry(int'(unsigned'(step_i)), fsel_i);
    addr_o = entry.addr;
    data_o = entry.data;
  end

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import phy_cal_pkg::*;
#(
  parameter bit ENABLE_CAL = 1'b1,
  parameter int NUM_STEPS  = CAL_STEPS,
  localparam int STEP_W    = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1,
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [CAL_FSEL_W-1:0] fsel_i,
  input  logic                  wr_ready_i,
  input  logic                  wr_timeout_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic                  wr_valid_o,
  output logic [STEP_W-1:0]     step_o,
  output logic [CAL_FSEL_W-1:0] fsel_q_o
);

  cal_state_e            state_q;
  logic [STEP_W-1:0]     step_q;
  logic [CAL_FSEL_W-1:0] fsel_q;
  logic                  err_q;

  // named events for the assertions
  logic start_take;
  logic wr_fin;
  logic last_fin;

  assign start_take = (state_q == CS_IDLE) && start_i;
  assign wr_valid_o = (state_q == CS_ISSUE);
  assign wr_fin     = wr_valid_o && (wr_ready_i || wr_timeout_i);
  assign last_fin   = wr_fin && (step_q == LAST_STEP);

  assign busy_o   = (state_q != CS_IDLE);
  assign done_o   = (state_q == CS_DONE);
  assign err_o    = err_q;
  assign step_o   = step_q;
  assign fsel_q_o = fsel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      step_q  <= '0;
      fsel_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        CS_IDLE: begin
          if (start_take) begin
            fsel_q  <= fsel_i;
            err_q   <= 1'b0;
            step_q  <= '0;
            state_q <= ENABLE_CAL ? CS_ISSUE : CS_DONE;
          end
        end
        CS_ISSUE: begin
          if (wr_fin) begin
            if (wr_timeout_i) err_q <= 1'b1;
            if (last_fin) state_q <= CS_DONE;
            else          step_q  <= step_q + 1'b1;
          end
        end
        CS_DONE:  state_q <= CS_IDLE;
        default:  state_q <= CS_IDLE;
      endcase
    end
  end

  assert_ignore_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(fsel_q));

  assert_timeout_sets_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fin && wr_timeout_i) |=> err_o);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_take) |=> err_o);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  assert_valid_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> busy_o);

  generate
    if (!ENABLE_CAL) begin : g_stub_chk
      assert_stub_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !wr_valid_o);
      assert_stub_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_take |=> (done_o && !err_o));
    end
  endgenerate

endmodule

// File: rtl/phy_cal_seq.sv
module phy_cal_seq
  import phy_cal_pkg::*;
#(
  parameter bit ENABLE_CAL = 1'b1,
  localparam int STEP_W = $clog2(CAL_STEPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [CAL_FSEL_W-1:0] fsel_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic [CAL_AW-1:0]     wr_addr_o,
  output logic [CAL_DW-1:0]     wr_data_o,
  output logic                  wr_valid_o,
  input  logic                  wr_ready_i,
  input  logic                  wr_timeout_i
);

  logic [STEP_W-1:0]     step;
  logic [CAL_FSEL_W-1:0] fsel_held;
  logic                  wr_fin;

  cal_seq_ctrl #(
    .ENABLE_CAL(ENABLE_CAL),
    .NUM_STEPS (CAL_STEPS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .fsel_i      (fsel_i),
    .wr_ready_i  (wr_ready_i),
    .wr_timeout_i(wr_timeout_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .wr_valid_o  (wr_valid_o),
    .step_o      (step),
    .fsel_q_o    (fsel_held)
  );

  cal_step_table #(
    .NUM_STEPS(CAL_STEPS)
  ) u_table (
    .step_i(step),
    .fsel_i(fsel_held),
    .addr_o(wr_addr_o),
    .data_o(wr_data_o)
  );

  assign wr_fin = wr_valid_o && (wr_ready_i || wr_timeout_i);

  generate
    if (ENABLE_CAL) begin : g_seq_chk
      assert_first_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (wr_valid_o && wr_addr_o == ADDR_LOS));

      assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i && !wr_timeout_i) |=>
          (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

      assert_order_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fin && wr_addr_o == ADDR_LOS) |=> (wr_valid_o && wr_addr_o == ADDR_BOOST));

      assert_order_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fin && wr_addr_o == ADDR_BOOST) |=> (wr_valid_o && wr_addr_o == ADDR_RXDET));

      assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fin && wr_addr_o == ADDR_RXDET) |=> (done_o && !wr_valid_o));
    end
  endgenerate

endmodule

// File: tb/sim_phy_cal_seq.sv
`timescale 1ns/1ps
module sim_phy_cal_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  fsel_in = 3'd0;
  logic        busy, done, err, wr_valid;
  logic [15:0] wr_addr, wr_data;
  logic        wr_ready = 1'b0;
  logic        wr_timeout = 1'b0;

  logic        start1 = 1'b0;
  logic        busy1, done1, err1, wr_valid1;
  logic [15:0] wr_addr1, wr_data1;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // scoreboard state
  logic [31:0] exp_q[$];
  int resp_delay = 0;
  int to_step = -1;
  int wr_idx = 0;
  int wait_cnt = 0;
  int last_acc = 0;
  bit seen = 1'b0;
  bit first_in_run = 1'b1;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_cal_seq #(.ENABLE_CAL(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .fsel_i(fsel_in),
    .busy_o(busy), .done_o(done), .err_o(err),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_valid_o(wr_valid),
    .wr_ready_i(wr_ready), .wr_timeout_i(wr_timeout)
  );

  phy_cal_seq #(.ENABLE_CAL(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start1), .fsel_i(3'd2),
    .busy_o(busy1), .done_o(done1), .err_o(err1),
    .wr_addr_o(wr_addr1), .wr_data_o(wr_data1), .wr_valid_o(wr_valid1),
    .wr_ready_i(1'b0), .wr_timeout_i(1'b0)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic logic [15:0] exp_rxdet(input int f);
    if (f == 0 || f == 1) return 16'h0040;
    if (f == 3)           return 16'h0200;
    return 16'h0080;
  endfunction

  // monitor + write-engine responder, one process so nothing races
  always @(negedge clk) begin
    wr_ready   = 1'b0;
    wr_timeout = 1'b0;
    if (wr_valid1) chk(1'b0, "R9 stub write", 1, 0);
    if (wr_valid) begin
      if (!seen) begin
        seen = 1'b1;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected write", {16'h0, wr_addr}, 0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          if (wr_idx == 0)      chk({wr_addr, wr_data} == e, "R2 write0", {wr_addr, wr_data}, e);
          else if (wr_idx == 1) chk({wr_addr, wr_data} == e, "R3 write1", {wr_addr, wr_data}, e);
          else                  chk({wr_addr, wr_data} == e, "R4 write2", {wr_addr, wr_data}, e);
        end
        if (!first_in_run) chk(cyc == last_acc + 1, "R5 back-to-back", cyc, last_acc + 1);
        first_in_run = 1'b0;
        wait_cnt = 0;
      end
      if (wait_cnt >= resp_delay) begin
        if (wr_idx == to_step) wr_timeout = 1'b1;
        else                   wr_ready   = 1'b1;
        last_acc = cyc;
        seen = 1'b0;
        wr_idx++;
      end else begin
        wait_cnt++;
      end
    end
  end

  // driver: pushes the expected writes, then waits for done
  task automatic run_cal(input int f, input int dly, input int tos, input bit poke);
    exp_q.push_back({16'h0015, 16'hA409});
    exp_q.push_back({16'h0012, 16'hA000});
    exp_q.push_back({16'h1010, exp_rxdet(f)});
    resp_delay = dly; to_step = tos; wr_idx = 0; first_in_run = 1'b1;
    @(negedge clk); start = 1'b1; fsel_in = 3'(f);
    @(negedge clk); start = 1'b0; fsel_in = 3'd3;
    chk(busy == 1'b1, "R2 busy", busy, 1);
    chk(err == 1'b0, "R8 err cleared by start", err, 0);
    if (poke) begin
      start = 1'b1;  // arrives while busy
      @(negedge clk); start = 1'b0;
    end
    for (int n = 0; n < 200 && !done; n++) @(negedge clk);
    chk(done == 1'b1, "R6 done seen", done, 1);
    chk(cyc == last_acc + 1, "R6 done timing", cyc, last_acc + 1);
    chk(err == (tos >= 0), "R8 err at done", err, tos >= 0);
    chk(exp_q.size() == 0, "R5 all writes issued", exp_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R6 single pulse", {done, busy}, 0);
    chk(err == (tos >= 0), "R8 err held", err, tos >= 0);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R7 no extra run", {busy, done}, 0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, err, wr_valid} == 4'b0, "R1 in reset", {busy, done, err, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, err, wr_valid} == 4'b0, "R1 after reset", {busy, done, err, wr_valid}, 0);

    run_cal(0, 0, -1, 1'b0);  // 19.2 MHz
    run_cal(1, 2, -1, 1'b0);  // 20 MHz
    run_cal(2, 1, -1, 1'b0);  // 24 MHz
    run_cal(3, 3, -1, 1'b0);  // 50 MHz
    run_cal(6, 0, -1, 1'b0);  // unlisted code
    run_cal(0, 4, -1, 1'b1);  // R7: start with 50 MHz while busy
    run_cal(2, 1, 1, 1'b0);   // R8: timeout on middle write
    run_cal(1, 0, 0, 1'b0);   // R8: new run clears, first write times out
    run_cal(3, 0, -1, 1'b0);  // clean run after an error

    // R9: stub variant
    @(negedge clk); start1 = 1'b1;
    @(negedge clk); start1 = 1'b0;
    chk(done1 == 1'b1 && err1 == 1'b0, "R9 stub done", {done1, err1}, 2);
    @(negedge clk);
    chk(done1 == 1'b0 && busy1 == 1'b0, "R9 stub idle", {done1, busy1}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule